// File: doc/BRIEF.md
# PWM Pin Override Priority Mux

This block sits between a PWM generator and the two pins of one complementary output channel. It receives the raw high-side and low-side PWM levels, five event inputs (debug freeze, two fault events, current limit and feed-forward) and a set of user override controls. From these it produces the final pin levels. An active event replaces both pin levels with a programmed 2-bit pattern. Current limit is the exception: it can instead invert the levels the generator path would otherwise drive.

The user override settings are a swap request, a per-pin override enable and per-pin override data. They are not applied as soon as they change. An internal active register copies them from the request ports only at a selected synchronization point: the start of a PWM cycle, every clock, the generator's update point, or the data-buffer update. Between those points the pins keep the old override state. The path from the raw PWM and event inputs to the pins is purely combinational, so events take effect in the same cycle.

Top module: `pwm_pin_override`

## Requirements
- R1: Priority, highest first: debug freeze, fault 1, fault 2, current limit, feed-forward, then the generator path (user override applied after swap, then raw PWM).
- R2: Each event pattern is 2 bits. Bit 1 sets `pin_hi` and bit 0 sets `pin_lo` while that event is the highest-priority active event.
- R3: The debug pattern `dbg_pat` is used only while both `debug_active` and `freeze_sel` are 1. With either of them at 0, debug has no effect on the pins.
- R4: The current-limit inversion applies when current limit is the winning event and both `clim_invert` and `compl_mode` are 1. Both pins then carry the inverse of the generator-path levels, and `clim_pat` is ignored.
- R5: When current limit wins and either `clim_invert` or `compl_mode` is 0, the pins carry `clim_pat`.
- R6: With active enable-high set, `pin_hi` follows active data bit 1. With active enable-low set, `pin_lo` follows active data bit 0. With an enable clear, that pin follows the (possibly swapped) raw PWM level.
- R7: With active swap set, raw high drives the low path and raw low drives the high path. The swap happens before the user override stage.
- R8: The active override settings load from `req_swap`, `req_en_hi`, `req_en_lo` and `req_dat` at a rising clock edge only when the event selected by `sync_sel` is present. The codes are 00 = `cyc_start`, 01 = every edge, 10 = `upd_point` and 11 = `buf_upd`. Otherwise the active settings hold, and request changes do not reach the pins.
- R9: A synchronous active-high `rst` clears the active settings: no swap, both enables off, data 00.
- R10: A change of raw PWM or an event input appears at the pins in the same cycle. A loaded override setting appears right after the loading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_hi | input | 1 | Generator high-side level |
| raw_lo | input | 1 | Generator low-side level |
| compl_mode | input | 1 | Channel runs in complementary mode |
| debug_active | input | 1 | Debug mode active |
| freeze_sel | input | 1 | Peripheral freeze selected |
| flt1_act | input | 1 | Fault event 1 active |
| flt2_act | input | 1 | Fault event 2 active |
| clim_act | input | 1 | Current limit active |
| ffwd_act | input | 1 | Feed-forward active |
| clim_invert | input | 1 | Current limit inverts instead of substituting |
| dbg_pat | input | 2 | Debug pattern {hi,lo} |
| flt1_pat | input | 2 | Fault 1 pattern {hi,lo} |
| flt2_pat | input | 2 | Fault 2 pattern {hi,lo} |
| clim_pat | input | 2 | Current-limit pattern {hi,lo} |
| ffwd_pat | input | 2 | Feed-forward pattern {hi,lo} |
| req_swap | input | 1 | Requested swap |
| req_en_hi | input | 1 | Requested high-pin override enable |
| req_en_lo | input | 1 | Requested low-pin override enable |
| req_dat | input | 2 | Requested override data {hi,lo} |
| sync_sel | input | 2 | Override load point select |
| cyc_start | input | 1 | PWM cycle start strobe |
| upd_point | input | 1 | Update-mode point strobe |
| buf_upd | input | 1 | Data-buffer update strobe |
| pin_hi | output | 1 | High-side pin level |
| pin_lo | output | 1 | Low-side pin level |

## Verification
The hardest situation to reach is a mismatch between the requested and the active override settings. Such a mismatch exists only between sync events, and only in the three strobe-driven modes. The bench runs each sync code with random requests and sparse random strobes, so that requests change many times between loads. It checks every cycle against a model that loads only on the selected strobe. A full sweep with loads on every edge also covers all combinations of the events, freeze, inversion mode, complementary mode, swap and enables, with random patterns.

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;

    typedef struct packed {
        logic hi;
        logic lo;
    } pin_pair_t;

    typedef enum logic [1:0] {
        SYNC_CYCLE  = 2'b00,
        SYNC_NOW    = 2'b01,
        SYNC_UPDPT  = 2'b10,
        SYNC_BUFUPD = 2'b11
    } sync_sel_e;

    typedef struct packed {
        logic      swap;
        logic      en_hi;
        logic      en_lo;
        pin_pair_t dat;
    } ovr_cfg_t;

    // event slots, index 0 = highest priority
    localparam int unsigned EVT_COUNT = 5;
    localparam int unsigned EVT_DBG   = 0;
    localparam int unsigned EVT_FLT1  = 1;
    localparam int unsigned EVT_FLT2  = 2;
    localparam int unsigned EVT_CLIM  = 3;
    localparam int unsigned EVT_FFWD  = 4;

    function automatic pin_pair_t flip_pair(pin_pair_t p);
        pin_pair_t r;
        r.hi = ~p.hi;
        r.lo = ~p.lo;
        return r;
    endfunction

    function automatic pin_pair_t cross_pair(pin_pair_t p, logic en);
        pin_pair_t r;
        r.hi = en ? p.lo : p.hi;
        r.lo = en ? p.hi : p.lo;
        return r;
    endfunction

    function automatic logic sync_hit(sync_sel_e s, logic cyc, logic upd, logic bupd);
        case (s)
            SYNC_CYCLE:  return cyc;
            SYNC_NOW:    return 1'b1;
            SYNC_UPDPT:  return upd;
            default:     return bupd;
        endcase
    endfunction

endpackage

// File: rtl/pwm_ovr_sync.sv
module pwm_ovr_sync
    import pwm_ovr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sync_sel_e sel,
    input  logic      cyc_start,
    input  logic      upd_point,
    input  logic      buf_upd,
    input  ovr_cfg_t  req,
    output ovr_cfg_t  act
);

    logic load_evt;

    always_comb begin
        load_evt = sync_hit(sel, cyc_start, upd_point, buf_upd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
        end else if (load_evt) begin
            act <= req;
        end
    end

    // R8
    hold_between_loads_chk: assert property (@(posedge clk) disable iff (rst)
        !load_evt |=> $stable(act));

    // R8
    now_mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SYNC_NOW) |=> (act == $past(req)));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (act == '0));

endmodule

// File: rtl/pwm_ovr_path.sv
module pwm_ovr_path
    import pwm_ovr_pkg::*;
(
    input  ovr_cfg_t  act,
    input  pin_pair_t raw,
    output pin_pair_t gen_out
);

    pin_pair_t crossed;

    always_comb begin
        crossed    = cross_pair(raw, act.swap);
        gen_out.hi = act.en_hi ? act.dat.hi : crossed.hi;
        gen_out.lo = act.en_lo ? act.dat.lo : crossed.lo;
    end

endmodule

// File: rtl/pwm_evt_mux.sv
module pwm_evt_mux
    import pwm_ovr_pkg::*;
#(
    parameter int unsigned NUM_EVT = EVT_COUNT,
    parameter int unsigned INV_IDX = EVT_CLIM
) (
    input  logic [NUM_EVT-1:0] evt_act,
    input  pin_pair_t          evt_pat [NUM_EVT],
    input  logic               inv_en,
    input  pin_pair_t          base,
    output pin_pair_t          pins
);

    logic [NUM_EVT-1:0] grant;

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_grant
        if (k == 0) begin : g_top
            assign grant[k] = evt_act[k];
        end else begin : g_rest
            assign grant[k] = evt_act[k] & ~(|evt_act[k-1:0]);
        end
    end

    always_comb begin
        pins = base;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (grant[k]) begin
                pins = (k == INV_IDX && inv_en) ? flip_pair(base) : evt_pat[k];
            end
        end
    end

endmodule

// File: rtl/pwm_pin_override.sv
module pwm_pin_override
    import pwm_ovr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raw_hi,
    input  logic       raw_lo,
    input  logic       compl_mode,
    input  logic       debug_active,
    input  logic       freeze_sel,
    input  logic       flt1_act,
    input  logic       flt2_act,
    input  logic       clim_act,
    input  logic       ffwd_act,
    input  logic       clim_invert,
    input  logic [1:0] dbg_pat,
    input  logic [1:0] flt1_pat,
    input  logic [1:0] flt2_pat,
    input  logic [1:0] clim_pat,
    input  logic [1:0] ffwd_pat,
    input  logic       req_swap,
    input  logic       req_en_hi,
    input  logic       req_en_lo,
    input  logic [1:0] req_dat,
    input  logic [1:0] sync_sel,
    input  logic       cyc_start,
    input  logic       upd_point,
    input  logic       buf_upd,
    output logic       pin_hi,
    output logic       pin_lo
);

    ovr_cfg_t           req_cfg;
    ovr_cfg_t           act_cfg;
    pin_pair_t          raw_pair;
    pin_pair_t          gen_out;
    pin_pair_t          final_pins;
    pin_pair_t          evt_pat [EVT_COUNT];
    logic [EVT_COUNT-1:0] evt_act;
    logic               dbg_freeze;

    assign req_cfg.swap  = req_swap;
    assign req_cfg.en_hi = req_en_hi;
    assign req_cfg.en_lo = req_en_lo;
    assign req_cfg.dat   = pin_pair_t'(req_dat);
    assign raw_pair.hi   = raw_hi;
    assign raw_pair.lo   = raw_lo;
    assign dbg_freeze    = debug_active & freeze_sel;

    assign evt_act[EVT_DBG]  = dbg_freeze;
    assign evt_act[EVT_FLT1] = flt1_act;
    assign evt_act[EVT_FLT2] = flt2_act;
    assign evt_act[EVT_CLIM] = clim_act;
    assign evt_act[EVT_FFWD] = ffwd_act;

    assign evt_pat[EVT_DBG]  = pin_pair_t'(dbg_pat);
    assign evt_pat[EVT_FLT1] = pin_pair_t'(flt1_pat);
    assign evt_pat[EVT_FLT2] = pin_pair_t'(flt2_pat);
    assign evt_pat[EVT_CLIM] = pin_pair_t'(clim_pat);
    assign evt_pat[EVT_FFWD] = pin_pair_t'(ffwd_pat);

    pwm_ovr_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .sel       (sync_sel_e'(sync_sel)),
        .cyc_start (cyc_start),
        .upd_point (upd_point),
        .buf_upd   (buf_upd),
        .req       (req_cfg),
        .act       (act_cfg)
    );

    pwm_ovr_path u_path (
        .act     (act_cfg),
        .raw     (raw_pair),
        .gen_out (gen_out)
    );

    pwm_evt_mux #(
        .NUM_EVT (EVT_COUNT),
        .INV_IDX (EVT_CLIM)
    ) u_mux (
        .evt_act (evt_act),
        .evt_pat (evt_pat),
        .inv_en  (clim_invert & compl_mode),
        .base    (gen_out),
        .pins    (final_pins)
    );

    assign pin_hi = final_pins.hi;
    assign pin_lo = final_pins.lo;

    // R3
    dbg_freeze_pat_chk: assert property (@(posedge clk) disable iff (rst)
        (debug_active && freeze_sel) |-> ({pin_hi, pin_lo} == dbg_pat));

    // R1
    flt1_over_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (!(debug_active && freeze_sel) && flt1_act) |-> ({pin_hi, pin_lo} == flt1_pat));

    // R5
    clim_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (!(debug_active && freeze_sel) && !flt1_act && !flt2_act && clim_act
         && !(clim_invert && compl_mode)) |-> ({pin_hi, pin_lo} == clim_pat));

    // R4
    clim_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (!(debug_active && freeze_sel) && !flt1_act && !flt2_act && clim_act
         && clim_invert && compl_mode) |-> (pin_hi != gen_out.hi && pin_lo != gen_out.lo));

    // R6
    ovr_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (!(debug_active && freeze_sel) && !flt1_act && !flt2_act && !clim_act && !ffwd_act
         && act_cfg.en_hi) |-> (pin_hi == act_cfg.dat.hi));

endmodule

// File: tb/test_pwm_pin_override.sv
`timescale 1ns/1ps
module test_pwm_pin_override;

    logic clk = 1'b0;
    logic rst;
    logic raw_hi, raw_lo, compl_mode, debug_active, freeze_sel;
    logic flt1_act, flt2_act, clim_act, ffwd_act, clim_invert;
    logic [1:0] dbg_pat, flt1_pat, flt2_pat, clim_pat, ffwd_pat;
    logic req_swap, req_en_hi, req_en_lo;
    logic [1:0] req_dat, sync_sel;
    logic cyc_start, upd_point, buf_upd;
    logic pin_hi, pin_lo;

    int errors = 0;
    int checks = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    // bench model of the active override settings
    logic m_swap = 1'b0, m_en_hi = 1'b0, m_en_lo = 1'b0;
    logic [1:0] m_dat = 2'b00;

    always #2.5 clk = ~clk;

    pwm_pin_override i_pwm_pin_override (
        .clk(clk), .rst(rst), .raw_hi(raw_hi), .raw_lo(raw_lo),
        .compl_mode(compl_mode), .debug_active(debug_active), .freeze_sel(freeze_sel),
        .flt1_act(flt1_act), .flt2_act(flt2_act), .clim_act(clim_act), .ffwd_act(ffwd_act),
        .clim_invert(clim_invert), .dbg_pat(dbg_pat), .flt1_pat(flt1_pat),
        .flt2_pat(flt2_pat), .clim_pat(clim_pat), .ffwd_pat(ffwd_pat),
        .req_swap(req_swap), .req_en_hi(req_en_hi), .req_en_lo(req_en_lo),
        .req_dat(req_dat), .sync_sel(sync_sel), .cyc_start(cyc_start),
        .upd_point(upd_point), .buf_upd(buf_upd), .pin_hi(pin_hi), .pin_lo(pin_lo)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 5.0);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    function automatic logic [31:0] step_lfsr(logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    // expected pins and the requirement that decides them
    function automatic logic [1:0] expect_pins(output string tag);
        logic [1:0] gen;
        logic [1:0] res;
        logic sh, sl;
        sh = m_swap ? raw_lo : raw_hi;                 // R7
        sl = m_swap ? raw_hi : raw_lo;
        tag = m_swap ? "R7" : "R10";
        gen[1] = m_en_hi ? m_dat[1] : sh;              // R6
        gen[0] = m_en_lo ? m_dat[0] : sl;
        if (m_en_hi || m_en_lo) tag = "R6";
        res = gen;
        if (ffwd_act) begin res = ffwd_pat; tag = "R2"; end
        if (clim_act) begin
            if (clim_invert && compl_mode) begin res = ~gen; tag = "R4"; end
            else begin res = clim_pat; tag = "R5"; end
        end
        if (flt2_act) begin res = flt2_pat; tag = "R2"; end
        if (flt1_act) begin res = flt1_pat; tag = "R1"; end
        if (debug_active && freeze_sel) begin res = dbg_pat; tag = "R3"; end
        else if (debug_active && (flt1_act | flt2_act | clim_act | ffwd_act) == 1'b0) tag = "R3";
        return res;
    endfunction

    task automatic check_pins(string ctx);
        string tag;
        logic [1:0] exp;
        exp = expect_pins(tag);
        checks++;
        if ({pin_hi, pin_lo} !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual=%b expected=%b", tag, ctx, {pin_hi, pin_lo}, exp);
        end
    endtask

    // advance one clock; update model from inputs held across the edge
    task automatic clock_edge();
        logic hit;
        @(posedge clk);
        case (sync_sel)
            2'b00:   hit = cyc_start;
            2'b01:   hit = 1'b1;
            2'b10:   hit = upd_point;
            default: hit = buf_upd;
        endcase
        if (rst) begin
            m_swap = 0; m_en_hi = 0; m_en_lo = 0; m_dat = 2'b00;       // R9
        end else if (hit) begin
            m_swap = req_swap; m_en_hi = req_en_hi; m_en_lo = req_en_lo; m_dat = req_dat; // R8
        end
        @(negedge clk);
    endtask

    task automatic quiet_events();
        debug_active = 0; freeze_sel = 0; flt1_act = 0; flt2_act = 0;
        clim_act = 0; ffwd_act = 0;
    endtask

    initial begin
        rst = 1; raw_hi = 0; raw_lo = 0; compl_mode = 1; clim_invert = 0;
        quiet_events();
        dbg_pat = 2'b01; flt1_pat = 2'b10; flt2_pat = 2'b11; clim_pat = 2'b01; ffwd_pat = 2'b10;
        req_swap = 1; req_en_hi = 1; req_en_lo = 1; req_dat = 2'b11;
        sync_sel = 2'b01; cyc_start = 0; upd_point = 0; buf_upd = 0;
        @(negedge clk);
        clock_edge();
        clock_edge();
        // R9: reset state, requests held off by reset
        raw_hi = 1; raw_lo = 0;
        #0.5 check_pins("reset state raw pass");
        rst = 0;
        sync_sel = 2'b00;
        clock_edge();
        #0.5 check_pins("after reset, no cycle start");
        checks++;
        if ({pin_hi, pin_lo} !== 2'b10) begin
            errors++;
            $display("FAIL R9: actual=%b expected=10", {pin_hi, pin_lo});
        end

        // full sweep with loads on every edge (R1..R7, R10)
        sync_sel = 2'b01;
        for (int i = 0; i < 32768; i++) begin
            lfsr = step_lfsr(lfsr);
            raw_hi = i[0]; raw_lo = i[1]; flt1_act = i[2]; flt2_act = i[3];
            clim_act = i[4]; ffwd_act = i[5]; debug_active = i[6]; freeze_sel = i[7];
            clim_invert = i[8]; compl_mode = i[9]; req_swap = i[10];
            req_en_hi = i[11]; req_en_lo = i[12]; req_dat = i[14:13];
            dbg_pat = lfsr[1:0]; flt1_pat = lfsr[3:2]; flt2_pat = lfsr[5:4];
            clim_pat = lfsr[7:6]; ffwd_pat = lfsr[9:8];
            #0.5 check_pins("sweep");
            clock_edge();
            #0.5 check_pins("sweep after load");
        end

        // strobe-driven sync modes (R8)
        quiet_events();
        for (int m = 0; m < 4; m++) begin
            sync_sel = 2'(m);
            for (int c = 0; c < 3000; c++) begin
                lfsr = step_lfsr(lfsr);
                raw_hi = lfsr[0]; raw_lo = lfsr[1];
                req_swap = lfsr[2]; req_en_hi = lfsr[3]; req_en_lo = lfsr[4];
                req_dat = lfsr[6:5];
                cyc_start = &lfsr[10:8];
                upd_point = &lfsr[13:11];
                buf_upd   = &lfsr[16:14];
                ffwd_act  = &lfsr[20:17];
                #0.5 check_pins($sformatf("R8 sync mode %0d", m));
                clock_edge();
            end
        end

        // R8: held request in cycle-start mode does not reach the pins
        ffwd_act = 0; cyc_start = 0; upd_point = 0; buf_upd = 0;
        sync_sel = 2'b01; req_swap = 0; req_en_hi = 0; req_en_lo = 0; req_dat = 2'b00;
        clock_edge();
        sync_sel = 2'b00; req_en_hi = 1; req_en_lo = 1; req_dat = 2'b01;
        raw_hi = 1; raw_lo = 0;
        clock_edge(); clock_edge();
        #0.5;
        checks++;
        if ({pin_hi, pin_lo} !== 2'b10) begin
            errors++;
            $display("FAIL R8 hold: actual=%b expected=10", {pin_hi, pin_lo});
        end
        cyc_start = 1;
        clock_edge();
        cyc_start = 0;
        #0.5;
        checks++;
        if ({pin_hi, pin_lo} !== 2'b01) begin
            errors++;
            $display("FAIL R8 load: actual=%b expected=01", {pin_hi, pin_lo});
        end

        summary();
        $finish;
    end

endmodule